// File: doc/BRIEF.md
# Operand-Triggered Dataflow Processing Element

This block is one compute tile for a coarse-grain array. It has no program counter and no instruction stream. It fires when its operands arrive and its output slot is free. A configuration port loads a small control word. The word selects the operation, an optional constant that can replace the second operand, and how two incoming event lines are combined. Data travels on three operand ports and one result port, each a valid/ready channel. One-bit packets on a selector channel can gate or steer the data.

Every result leaves together with a bundle of event bits. These are zero, negative, carry/borrow, overflow, comparison and counter-terminated, and they behave like processor status flags. Neighbouring tiles can consume the bundle. A separate combiner merges two one-bit event strobes into one output strobe, either as soon as either strobe arrives or only after both have arrived.

The tile computes as soon as it holds a configuration, whatever the state of its neighbours. A clear command returns it to the unconfigured state, where it takes nothing and offers nothing.

Top module: `dfe_top`

## Requirements
- R1: The element fires only when every operand that the loaded opcode needs is valid. All needed inputs are consumed in the same cycle, and no input that the opcode does not need is consumed.
- R2: While a result is held with `y_ready` low, `y_data` and `y_evt` stay stable and every input ready is low. The held result is replaced only in a cycle where it is taken.
- R3: With the output always accepted, one packet per cycle passes with no input stall. Under an irregular `y_ready` pattern, every packet comes out once, in order.
- R4: The opcodes are 0 add, 1 subtract, 2 multiply (low 32 bits kept), 3 AND, 4 OR, 5 XOR, and 11 to 15 pass A. When the constant-select bit is set, the constant replaces B and B is not consumed.
- R5: Opcode 6 computes A*B+C, keeping the low 32 bits. Opcode 7 outputs the signed minimum of A and B and raises the comparison event when B is below A.
- R6: Opcode 8 is a counter stepped by each A packet. It outputs 0, 1, …, K-1 and then wraps, where K is the constant and K ≥ 1. The terminate event (`y_evt[5]`) is set only on the packet carrying K-1.
- R7: The `y_evt` bit positions are fixed: bit 0 means the result is zero, bit 1 is the result sign, and bit 2 is the add carry-out or subtract borrow. Bit 3 is signed overflow for add and subtract, and for multiply and multiply-add it means a non-zero upper half. Bit 4 is the minimum's comparison. These bits go out with their result.
- R8: Opcode 9 takes A and one selector packet. A selector value of 1 discards A with no output, and 0 forwards A. Opcode 10 takes a selector packet and forwards B when it is 1 or A when it is 0, consuming only the chosen stream.
- R9: In OR mode, `ev_out` pulses one cycle after either `ev_in0` or `ev_in1` pulses. In AND mode it pulses one cycle after both have been seen, in any order, and the collected state then clears.
- R10: `cfg_word` holds the opcode in [3:0], the AND-mode bit in [4], the constant-select bit in [5] and the constant in [37:6]. Before the first write and after `cfg_clr`, all input readies and `y_valid` are low. Data is accepted in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load `cfg_word` and become configured |
| cfg_clr | input | 1 | Return to unconfigured, dropping any held result |
| cfg_word | input | 38 | Opcode, mode bits and constant |
| a_data | input | 32 | Operand A |
| a_valid | input | 1 | Operand A present |
| a_ready | output | 1 | Operand A consumed this cycle |
| b_data | input | 32 | Operand B |
| b_valid | input | 1 | Operand B present |
| b_ready | output | 1 | Operand B consumed this cycle |
| c_data | input | 32 | Operand C |
| c_valid | input | 1 | Operand C present |
| c_ready | output | 1 | Operand C consumed this cycle |
| sel_bit | input | 1 | Selector event value |
| sel_valid | input | 1 | Selector event present |
| sel_ready | output | 1 | Selector event consumed |
| ev_in0 | input | 1 | Event strobe 0 for the combiner |
| ev_in1 | input | 1 | Event strobe 1 for the combiner |
| ev_out | output | 1 | Combined event strobe |
| y_data | output | 32 | Result |
| y_valid | output | 1 | Result present |
| y_ready | input | 1 | Downstream accepts result |
| y_evt | output | 6 | Result event bits |

## Verification
Some properties are checked on every cycle. These are the all-or-nothing consumption of binary and three-operand inputs, the frozen result and blocked inputs during a stall, the empty output after a gated discard, the agreement of the zero bit with the data, the causality of the combined event strobe, and the silence of an unconfigured tile. Other behaviour can only be shown by the bench's scenarios. This covers the arithmetic and flag values for each opcode, the counter wrap and its single terminate event, merge steering, ordering and completeness under irregular backpressure, and the full one-per-cycle rate.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_MUL   = 4'd2,
      OP_AND   = 4'd3,
      OP_OR    = 4'd4,
      OP_XOR   = 4'd5,
      OP_MADD  = 4'd6,
      OP_SORT  = 4'd7,
      OP_CNT   = 4'd8,
      OP_GATE  = 4'd9,
      OP_MERGE = 4'd10,
      OP_PASS  = 4'd11
   } op_e;

   // event bundle layout carried with each result
   localparam int EVW     = 6;
   localparam int EV_ZERO = 0;
   localparam int EV_NEG  = 1;
   localparam int EV_CARRY= 2;
   localparam int EV_OVF  = 3;
   localparam int EV_CMP  = 4;
   localparam int EV_TERM = 5;

   // configuration word field positions (constant sits above these)
   localparam int CFG_OP_LO  = 0;
   localparam int CFG_AND_B  = 4;
   localparam int CFG_BC_B   = 5;
   localparam int CFG_K_LO   = 6;

   typedef struct packed {
      logic b_const;
      logic ev_and;
      op_e  op;
   } ctl_t;

endpackage

// File: rtl/dfe_alu.sv
module dfe_alu
   import dfe_pkg::*;
#(
   parameter int DW = 32
) (
   input  op_e           op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] c,
   output logic [DW-1:0] res,
   output logic          carry,
   output logic          ovf,
   output logic          cmp
);

   localparam int PW = 2 * DW;

   logic [DW:0]   sum;
   logic [DW:0]   diff;
   logic [PW-1:0] prod;
   logic [PW-1:0] madd;
   logic          lt_ba;

   assign sum   = {1'b0, a} + {1'b0, b};
   assign diff  = {1'b0, a} - {1'b0, b};
   assign prod  = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
   assign madd  = prod + {{DW{1'b0}}, c};
   assign lt_ba = $signed(b) < $signed(a);

   always_comb begin
      res   = a;
      carry = 1'b0;
      ovf   = 1'b0;
      cmp   = 1'b0;
      case (op)
         OP_ADD: begin
            res   = sum[DW-1:0];
            carry = sum[DW];
            ovf   = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
         end
         OP_SUB: begin
            res   = diff[DW-1:0];
            carry = diff[DW];
            ovf   = (a[DW-1] != b[DW-1]) && (diff[DW-1] != a[DW-1]);
         end
         OP_MUL: begin
            res = prod[DW-1:0];
            ovf = |prod[PW-1:DW];
         end
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_MADD: begin
            res = madd[DW-1:0];
            ovf = |madd[PW-1:DW];
         end
         OP_SORT: begin
            res = lt_ba ? b : a;
            cmp = lt_ba;
         end
         default: res = a;
      endcase
   end

endmodule

// File: rtl/dfe_fire.sv
module dfe_fire
   import dfe_pkg::*;
#(
   parameter int NUM_IN = 3
) (
   input  logic cfg_ok,
   input  op_e  op,
   input  logic b_const,
   input  logic a_v,
   input  logic b_v,
   input  logic c_v,
   input  logic s_v,
   input  logic s_bit,
   input  logic slot_free,
   output logic fire,
   output logic a_rdy,
   output logic b_rdy,
   output logic c_rdy,
   output logic s_rdy,
   output logic drop,
   output logic pick_b
);

   localparam bit HAS_C = (NUM_IN == 3);

   logic need_a, need_b, need_c, need_s, avail;

   always_comb begin
      need_a = 1'b1;
      need_b = 1'b0;
      need_c = 1'b0;
      need_s = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR, OP_SORT:
            need_b = !b_const;
         OP_MADD: begin
            need_b = !b_const;
            need_c = HAS_C;
         end
         OP_GATE:  need_s = 1'b1;
         OP_MERGE: begin
            need_s = 1'b1;
            need_a = !s_bit;
            need_b = s_bit;
         end
         default: ;
      endcase
   end

   assign avail  = (!need_a || a_v) && (!need_b || b_v) &&
                   (!need_c || c_v) && (!need_s || s_v);
   assign fire   = cfg_ok && slot_free && avail;
   assign a_rdy  = fire && need_a;
   assign b_rdy  = fire && need_b;
   assign c_rdy  = fire && need_c;
   assign s_rdy  = fire && need_s;
   assign drop   = (op == OP_GATE) && s_bit;
   assign pick_b = (op == OP_MERGE) && s_bit;

endmodule

// File: rtl/dfe_evcomb.sv
module dfe_evcomb (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   input  logic and_mode,
   input  logic ev0,
   input  logic ev1,
   output logic ev_o
);

   logic seen0, seen1;
   logic hit0, hit1;

   assign hit0 = seen0 || ev0;
   assign hit1 = seen1 || ev1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen0 <= 1'b0;
         seen1 <= 1'b0;
         ev_o  <= 1'b0;
      end else if (!en || clr) begin
         seen0 <= 1'b0;
         seen1 <= 1'b0;
         ev_o  <= 1'b0;
      end else if (!and_mode) begin
         seen0 <= 1'b0;
         seen1 <= 1'b0;
         ev_o  <= ev0 || ev1;
      end else if (hit0 && hit1) begin
         seen0 <= 1'b0;
         seen1 <= 1'b0;
         ev_o  <= 1'b1;
      end else begin
         seen0 <= hit0;
         seen1 <= hit1;
         ev_o  <= 1'b0;
      end
   end

endmodule

// File: rtl/dfe_top.sv
module dfe_top
   import dfe_pkg::*;
#(
   parameter int DW     = 32,
   parameter int NUM_IN = 3,
   localparam int CFG_W = DW + CFG_K_LO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_clr,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic [DW-1:0]    a_data,
   input  logic             a_valid,
   output logic             a_ready,
   input  logic [DW-1:0]    b_data,
   input  logic             b_valid,
   output logic             b_ready,
   input  logic [DW-1:0]    c_data,
   input  logic             c_valid,
   output logic             c_ready,
   input  logic             sel_bit,
   input  logic             sel_valid,
   output logic             sel_ready,
   input  logic             ev_in0,
   input  logic             ev_in1,
   output logic             ev_out,
   output logic [DW-1:0]    y_data,
   output logic             y_valid,
   input  logic             y_ready,
   output logic [EVW-1:0]   y_evt
);

   if (DW < 8) begin : g_bad_dw
      $error("dfe_top: DW must be at least 8");
   end
   if (NUM_IN != 2 && NUM_IN != 3) begin : g_bad_nin
      $error("dfe_top: NUM_IN must be 2 or 3");
   end

   logic          cfg_ok;
   ctl_t          ctl;
   logic [DW-1:0] cst;
   logic [DW-1:0] cnt;

   logic          fire, drop, pick_b, slot_free;
   logic [DW-1:0] a_op, b_op, c_op;
   logic [DW-1:0] alu_res, res;
   logic          alu_carry, alu_ovf, alu_cmp;
   logic          is_cnt, cnt_last;
   logic [EVW-1:0] evt;

   assign slot_free = !y_valid || y_ready;
   assign is_cnt    = (ctl.op == OP_CNT);
   assign cnt_last  = (cnt + DW'(1)) == cst;

   // configuration register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_ok <= 1'b0;
         ctl    <= '0;
         cst    <= '0;
      end else if (cfg_clr) begin
         cfg_ok <= 1'b0;
      end else if (cfg_we) begin
         cfg_ok      <= 1'b1;
         ctl.op      <= op_e'(cfg_word[CFG_OP_LO +: 4]);
         ctl.ev_and  <= cfg_word[CFG_AND_B];
         ctl.b_const <= cfg_word[CFG_BC_B];
         cst         <= cfg_word[CFG_K_LO +: DW];
      end
   end

   dfe_fire #(.NUM_IN(NUM_IN)) u_fire (
      .cfg_ok    (cfg_ok),
      .op        (ctl.op),
      .b_const   (ctl.b_const),
      .a_v       (a_valid),
      .b_v       (b_valid),
      .c_v       (c_valid),
      .s_v       (sel_valid),
      .s_bit     (sel_bit),
      .slot_free (slot_free),
      .fire      (fire),
      .a_rdy     (a_ready),
      .b_rdy     (b_ready),
      .c_rdy     (c_ready),
      .s_rdy     (sel_ready),
      .drop      (drop),
      .pick_b    (pick_b)
   );

   // operand selection
   assign a_op = pick_b ? b_data : a_data;
   assign b_op = ctl.b_const ? cst : b_data;

   if (NUM_IN == 3) begin : g_c_port
      assign c_op = c_data;
   end else begin : g_c_const
      assign c_op = cst;
   end

   dfe_alu #(.DW(DW)) u_alu (
      .op    (ctl.op),
      .a     (a_op),
      .b     (b_op),
      .c     (c_op),
      .res   (alu_res),
      .carry (alu_carry),
      .ovf   (alu_ovf),
      .cmp   (alu_cmp)
   );

   assign res = is_cnt ? cnt : alu_res;

   always_comb begin
      evt           = '0;
      evt[EV_ZERO]  = (res == '0);
      evt[EV_NEG]   = res[DW-1];
      evt[EV_CARRY] = alu_carry;
      evt[EV_OVF]   = alu_ovf;
      evt[EV_CMP]   = alu_cmp;
      evt[EV_TERM]  = is_cnt && cnt_last;
   end

   // step counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cfg_we) begin
         cnt <= '0;
      end else if (fire && is_cnt) begin
         cnt <= cnt_last ? '0 : cnt + DW'(1);
      end
   end

   // single-entry output slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_valid <= 1'b0;
         y_data  <= '0;
         y_evt   <= '0;
      end else if (cfg_clr) begin
         y_valid <= 1'b0;
      end else if (fire && !drop) begin
         y_valid <= 1'b1;
         y_data  <= res;
         y_evt   <= evt;
      end else if (y_ready) begin
         y_valid <= 1'b0;
      end
   end

   dfe_evcomb u_evc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_ok),
      .clr      (cfg_we),
      .and_mode (ctl.ev_and),
      .ev0      (ev_in0),
      .ev1      (ev_in1),
      .ev_o     (ev_out)
   );

endmodule

// File: rtl/dfe_chk.sv
module dfe_chk
   import dfe_pkg::*;
#(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_ok,
   input logic          cfg_clr,
   input op_e           op,
   input logic          b_const,
   input logic          a_valid,
   input logic          a_ready,
   input logic          b_valid,
   input logic          b_ready,
   input logic          c_valid,
   input logic          c_ready,
   input logic          sel_valid,
   input logic          sel_ready,
   input logic          sel_bit,
   input logic          ev_in0,
   input logic          ev_in1,
   input logic          ev_out,
   input logic [DW-1:0] y_data,
   input logic          y_valid,
   input logic          y_ready,
   input logic [EVW-1:0] y_evt
);

   logic binop;
   assign binop = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) ||
                  (op == OP_AND) || (op == OP_OR)  || (op == OP_XOR) ||
                  (op == OP_SORT);

   // R1: a binary op takes both operands together or neither
   a_r1_pair_consume: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ok && binop && !b_const && (a_ready || b_ready)
      |-> a_valid && b_valid && a_ready && b_ready);

   // R1: the third operand is taken only alongside A
   a_r1_c_with_a: assert property (@(posedge clk) disable iff (!rst_n)
      c_ready |-> c_valid && a_valid && a_ready);

   // R2: a stalled result stays frozen
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid && !y_ready && !cfg_clr |=> y_valid && $stable(y_data) && $stable(y_evt));

   // R2: a stalled result blocks every input
   a_r2_stall: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid && !y_ready |-> !a_ready && !b_ready && !c_ready && !sel_ready);

   // R7: zero event agrees with the data it travels with
   a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid |-> (y_evt[EV_ZERO] == (y_data == '0)));

   // R8: a discarded packet leaves the output empty
   a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ok && op == OP_GATE && sel_ready && sel_bit && !cfg_clr |=> !y_valid);

   // R9: a combined event always follows an incoming one
   a_r9_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ev_out |-> $past(ev_in0 || ev_in1));

   // R10: an unconfigured element is silent
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ok |-> !a_ready && !b_ready && !c_ready && !sel_ready && !y_valid);

endmodule

bind dfe_top dfe_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_ok    (cfg_ok),
   .cfg_clr   (cfg_clr),
   .op        (ctl.op),
   .b_const   (ctl.b_const),
   .a_valid   (a_valid),
   .a_ready   (a_ready),
   .b_valid   (b_valid),
   .b_ready   (b_ready),
   .c_valid   (c_valid),
   .c_ready   (c_ready),
   .sel_valid (sel_valid),
   .sel_ready (sel_ready),
   .sel_bit   (sel_bit),
   .ev_in0    (ev_in0),
   .ev_in1    (ev_in1),
   .ev_out    (ev_out),
   .y_data    (y_data),
   .y_valid   (y_valid),
   .y_ready   (y_ready),
   .y_evt     (y_evt)
);

// File: tb/dfe_top_bench.sv
module dfe_top_bench;

   localparam int DW    = 32;
   localparam int CFG_W = DW + 6;
   localparam int VW    = 171;
   localparam int NV    = 14;
   localparam int NS    = 16;

   // {op, bconst, k, a, b, c, y, evt[5:0] = term,cmp,ovf,carry,neg,zero}
   localparam logic [VW-1:0] VEC [NV] = '{
      {4'd0, 1'b0, 32'd0, 32'd5,          32'd7,          32'd0, 32'd12,         6'b000000},
      {4'd0, 1'b0, 32'd0, 32'hFFFFFFFF,   32'd1,          32'd0, 32'd0,          6'b000101},
      {4'd0, 1'b0, 32'd0, 32'h7FFFFFFF,   32'd1,          32'd0, 32'h80000000,   6'b001010},
      {4'd1, 1'b0, 32'd0, 32'd3,          32'd5,          32'd0, 32'hFFFFFFFE,   6'b000110},
      {4'd1, 1'b0, 32'd0, 32'h80000000,   32'd1,          32'd0, 32'h7FFFFFFF,   6'b001000},
      {4'd2, 1'b0, 32'd0, 32'h00010000,   32'h00010000,   32'd0, 32'd0,          6'b001001},
      {4'd2, 1'b0, 32'd0, 32'd6,          32'd7,          32'd0, 32'd42,         6'b000000},
      {4'd3, 1'b0, 32'd0, 32'h0000F0F0,   32'h0000FF00,   32'd0, 32'h0000F000,   6'b000000},
      {4'd4, 1'b1, 32'h0F, 32'h000000F0,  32'h0000DEAD,   32'd0, 32'h000000FF,   6'b000000},
      {4'd5, 1'b0, 32'd0, 32'hFFFFFFFF,   32'h0F0F0F0F,   32'd0, 32'hF0F0F0F0,   6'b000010},
      {4'd6, 1'b0, 32'd0, 32'd3,          32'd4,          32'd5, 32'd17,         6'b000000},
      {4'd6, 1'b0, 32'd0, 32'hFFFFFFFF,   32'd2,          32'd2, 32'd0,          6'b001001},
      {4'd7, 1'b0, 32'd0, 32'd5,          32'hFFFFFFFD,   32'd0, 32'hFFFFFFFD,   6'b010010},
      {4'd7, 1'b0, 32'd0, 32'd2,          32'd9,          32'd0, 32'd2,          6'b000000}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cfg_we, cfg_clr;
   logic [CFG_W-1:0] cfg_word;
   logic [DW-1:0]    a_data, b_data, c_data;
   logic             a_valid, b_valid, c_valid;
   logic             a_ready, b_ready, c_ready;
   logic             sel_bit, sel_valid, sel_ready;
   logic             ev_in0, ev_in1, ev_out;
   logic [DW-1:0]    y_data;
   logic             y_valid, y_ready;
   logic [5:0]       y_evt;

   int checks = 0;
   int fails  = 0;
   logic ra, rb, rc, rs;
   int stalls;

   always #2.5 clk = ~clk;

   dfe_top u_dfe_top (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_clr(cfg_clr), .cfg_word(cfg_word),
      .a_data(a_data), .a_valid(a_valid), .a_ready(a_ready),
      .b_data(b_data), .b_valid(b_valid), .b_ready(b_ready),
      .c_data(c_data), .c_valid(c_valid), .c_ready(c_ready),
      .sel_bit(sel_bit), .sel_valid(sel_valid), .sel_ready(sel_ready),
      .ev_in0(ev_in0), .ev_in1(ev_in1), .ev_out(ev_out),
      .y_data(y_data), .y_valid(y_valid), .y_ready(y_ready), .y_evt(y_evt)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic configure(input logic [3:0] op, input logic bc, input logic ea,
                            input logic [DW-1:0] k);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_word = {k, bc, ea, op};
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   // drive operands at a negedge, wait for the firing edge, release at the next negedge
   task automatic offer(input logic av, input logic [DW-1:0] a, input logic bv,
                        input logic [DW-1:0] b, input logic cv, input logic [DW-1:0] c,
                        input logic sv, input logic sb);
      logic got;
      a_valid = av; a_data = a;
      b_valid = bv; b_data = b;
      c_valid = cv; c_data = c;
      sel_valid = sv; sel_bit = sb;
      got = 1'b0;
      while (!got) begin
         #1;
         if (a_ready || b_ready || c_ready || sel_ready) begin
            got = 1'b1;
            ra = a_ready; rb = b_ready; rc = c_ready; rs = sel_ready;
         end else begin
            @(negedge clk);
         end
      end
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0; c_valid = 1'b0; sel_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_clr = 1'b0; cfg_word = '0;
      a_data = '0; b_data = '0; c_data = '0;
      a_valid = 1'b0; b_valid = 1'b0; c_valid = 1'b0;
      sel_bit = 1'b0; sel_valid = 1'b0; ev_in0 = 1'b0; ev_in1 = 1'b0;
      y_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state, unconfigured element refuses everything
      @(negedge clk);
      a_valid = 1'b1; b_valid = 1'b1; c_valid = 1'b1; sel_valid = 1'b1;
      #1;
      chk("R10 reset readies", {a_ready, b_ready, c_ready, sel_ready}, 4'b0000);
      chk("R10 reset y_valid", y_valid, 1'b0);
      chk("R9 reset ev_out", ev_out, 1'b0);
      a_valid = 1'b0; b_valid = 1'b0; c_valid = 1'b0; sel_valid = 1'b0;

      // R4 R5 R7: table of operations and event bits
      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         logic [3:0] op;
         v  = VEC[i];
         op = v[170:167];
         configure(op, v[166], 1'b0, v[165:134]);
         offer(1'b1, v[133:102], !v[166], v[101:70], op == 4'd6, v[69:38], 1'b0, 1'b0);
         chk($sformatf("R4/R5 vec%0d data", i), y_data, v[37:6]);
         chk($sformatf("R7 vec%0d evt", i), y_evt, v[5:0]);
         chk($sformatf("R4 vec%0d b consumed", i), rb, !v[166]);
      end

      // R1: add waits for B, then takes both together
      configure(4'd0, 1'b0, 1'b0, 32'd0);
      @(negedge clk);
      a_valid = 1'b1; a_data = 32'd100;
      repeat (2) @(negedge clk);
      #1;
      chk("R1 A alone not taken", a_ready, 1'b0);
      chk("R1 no output without B", y_valid, 1'b0);
      @(negedge clk);
      offer(1'b1, 32'd100, 1'b1, 32'd23, 1'b1, 32'd9, 1'b0, 1'b0);
      chk("R1 pair taken", {ra, rb, rc}, 3'b110);
      chk("R1 sum", y_data, 32'd123);

      // R2: backpressure holds result and blocks inputs
      @(negedge clk);
      y_ready = 1'b0;
      offer(1'b1, 32'd1, 1'b1, 32'd1, 1'b0, 32'd0, 1'b0, 1'b0);
      a_valid = 1'b1; a_data = 32'd10; b_valid = 1'b1; b_data = 32'd10;
      #1;
      chk("R2 inputs blocked", {a_ready, b_ready}, 2'b00);
      repeat (3) @(negedge clk);
      chk("R2 held valid", y_valid, 1'b1);
      chk("R2 held data", y_data, 32'd2);
      y_ready = 1'b1;
      #1;
      chk("R2 fires when slot frees", {a_ready, b_ready}, 2'b11);
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
      chk("R2 replaced on take", y_data, 32'd20);

      // R3: streaming, first at full rate then under irregular backpressure
      configure(4'd0, 1'b1, 1'b0, 32'd1);
      for (int phase = 0; phase < 2; phase++) begin
         int rcv;
         stalls = 0;
         rcv = 0;
         fork
            begin
               for (int i = 0; i < NS; i++) begin
                  logic took;
                  @(negedge clk);
                  a_valid = 1'b1; a_data = DW'(i * 7);
                  took = 1'b0;
                  while (!took) begin
                     #1;
                     if (a_ready) took = 1'b1;
                     else begin
                        stalls++;
                        @(negedge clk);
                     end
                  end
                  @(posedge clk);
               end
               @(negedge clk);
               a_valid = 1'b0;
            end
            begin
               int cyc;
               cyc = 0;
               while (rcv < NS) begin
                  @(negedge clk);
                  cyc++;
                  y_ready = (phase == 0) ? 1'b1 : ((cyc % 3) != 0);
                  if (y_valid && y_ready) begin
                     chk("R3 order", y_data, DW'(rcv * 7 + 1));
                     rcv++;
                  end
               end
            end
         join
         @(negedge clk);
         y_ready = 1'b1;
         chk("R3 all delivered", rcv, NS);
         if (phase == 0) chk("R3 no stall at full rate", stalls, 0);
         @(negedge clk);
         chk("R3 no extra packet", y_valid, 1'b0);
      end

      // R6: counter with limit 3
      configure(4'd8, 1'b0, 1'b0, 32'd3);
      for (int i = 0; i < 6; i++) begin
         offer(1'b1, 32'hABCD, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0);
         chk("R6 count", y_data, DW'(i % 3));
         chk("R6 term event", y_evt[5], (i % 3) == 2);
      end

      // R8: gate discards on selector 1, forwards on 0
      configure(4'd9, 1'b0, 1'b0, 32'd0);
      offer(1'b1, 32'h55, 1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1);
      chk("R8 discard consumes", {ra, rs}, 2'b11);
      chk("R8 discard no output", y_valid, 1'b0);
      offer(1'b1, 32'h66, 1'b0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b0);
      chk("R8 gate forwards", y_data, 32'h66);
      chk("R8 gate valid", y_valid, 1'b1);

      // R8: merge chooses stream by selector
      configure(4'd10, 1'b0, 1'b0, 32'd0);
      offer(1'b1, 32'h11, 1'b1, 32'h22, 1'b0, 32'd0, 1'b1, 1'b1);
      chk("R8 merge picks B", y_data, 32'h22);
      chk("R8 merge leaves A", {ra, rb}, 2'b01);
      offer(1'b1, 32'h11, 1'b1, 32'h33, 1'b0, 32'd0, 1'b1, 1'b0);
      chk("R8 merge picks A", y_data, 32'h11);
      chk("R8 merge leaves B", {ra, rb}, 2'b10);

      // R9: event combiner OR then AND
      configure(4'd0, 1'b0, 1'b0, 32'd0);
      @(negedge clk); ev_in1 = 1'b1;
      @(negedge clk); ev_in1 = 1'b0;
      chk("R9 OR fires", ev_out, 1'b1);
      @(negedge clk);
      chk("R9 OR one pulse", ev_out, 1'b0);
      configure(4'd0, 1'b0, 1'b1, 32'd0);
      @(negedge clk); ev_in0 = 1'b1;
      @(negedge clk); ev_in0 = 1'b0;
      chk("R9 AND waits", ev_out, 1'b0);
      @(negedge clk); ev_in1 = 1'b1;
      @(negedge clk); ev_in1 = 1'b0;
      chk("R9 AND fires", ev_out, 1'b1);
      @(negedge clk); ev_in1 = 1'b1;
      @(negedge clk); ev_in1 = 1'b0;
      chk("R9 AND cleared", ev_out, 1'b0);
      @(negedge clk); ev_in0 = 1'b1;
      @(negedge clk); ev_in0 = 1'b0;
      chk("R9 AND completes later", ev_out, 1'b1);

      // R10: clear drops a held result and silences the element
      @(negedge clk);
      y_ready = 1'b0;
      offer(1'b1, 32'd4, 1'b1, 32'd4, 1'b0, 32'd0, 1'b0, 1'b0);
      chk("R10 held before clear", y_valid, 1'b1);
      cfg_clr = 1'b1;
      @(negedge clk);
      cfg_clr = 1'b0;
      a_valid = 1'b1; b_valid = 1'b1;
      #1;
      chk("R10 cleared valid", y_valid, 1'b0);
      chk("R10 cleared readies", {a_ready, b_ready}, 2'b00);
      a_valid = 1'b0; b_valid = 1'b0;
      y_ready = 1'b1;

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule